// File: doc/BRIEF.md
# AXI blocking firewall flush engine

This block sits between an upstream AXI4 subordinate port and a downstream AXI4 manager port. In normal mode it is transparent. Commands, write data, read data and write responses pass straight through. All the while, it records every outstanding read and write in two age-ordered tracking queues. Each entry holds the transaction ID and the number of beats still owed.

When the block trigger is raised, the engine cuts off the downstream side. It stops driving command and write-data valids downstream, and it holds the downstream response readies high so that stray responses are absorbed. It then answers everything still outstanding upstream by itself. Read bursts receive their remaining beats filled with a fixed error pattern, and writes receive an error response once their last data beat has arrived. Commands that arrive upstream during the block are accepted, queued and answered the same way. They are never forwarded.

Two busy flags tell the surrounding logic when the flush is complete. An unblock request is honoured only when both flags are low. The engine then returns to pass-through with empty queues.

Top module: `axf_fw`

## Requirements
- R1: In normal mode, AR, AW and W payloads are forwarded unchanged downstream, and R and B payloads are forwarded unchanged upstream, with the ready signals passed back.
- R2: While blocked, m_arvalid, m_awvalid and m_wvalid are 0, and m_rready and m_bready are 1.
- R3: When DEPTH reads are outstanding, s_arready is 0. When DEPTH writes are outstanding, s_awready is 0.
- R4: While blocked, each outstanding read receives its owed beats upstream. Every beat carries the read's ID, s_rresp = 2'b10, and s_rdata equal to 32'hDEADFA11 repeated across the width, with s_rlast = 1 only on the final beat. A stalled beat holds until it is accepted.
- R5: While blocked, a write receives s_bvalid with its ID and s_bresp = 2'b10 only after its wlast beat has been accepted upstream.
- R6: Flushed responses follow issue order, so responses within one ID keep their order.
- R7: AR and AW commands and W beats that arrive during a block are accepted upstream, answered by the engine, and never shown downstream.
- R8: rd_busy is 1 whenever a read is outstanding or s_arvalid is 1. wr_busy is 1 whenever a write is outstanding or s_awvalid or s_wvalid is 1. Each flag falls when its last outstanding transaction completes.
- R9: unblk_req takes effect only when both busy flags are low. After it does, the engine is in pass-through again.
- R10: A read that was partly answered downstream before the block receives only its remaining beats during the flush.
- R11: blk_req sampled high at a clock edge puts the engine into the blocked state from that edge onward. The engine stays blocked until an accepted unblock.
- R12: s_wready is 0 unless a recorded write still lacks its wlast beat, so a W beat is never accepted ahead of its AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_req | input | 1 | Block trigger |
| unblk_req | input | 1 | Unblock request |
| rd_busy | output | 1 | Read traffic outstanding or arriving |
| wr_busy | output | 1 | Write traffic outstanding or arriving |
| s_arvalid | input | 1 | Upstream read command valid |
| s_arready | output | 1 | Upstream read command ready |
| s_arid | input | ID_W | Read command ID |
| s_araddr | input | ADDR_W | Read address |
| s_arlen | input | LEN_W | Read beats minus one |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| s_awvalid | input | 1 | Upstream write command valid |
| s_awready | output | 1 | Upstream write command ready |
| s_awid | input | ID_W | Write command ID |
| s_awaddr | input | ADDR_W | Write address |
| s_awlen | input | LEN_W | Write beats minus one |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wlast | input | 1 | Last write beat |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| m_arvalid | output | 1 | Downstream read command valid |
| m_arready | input | 1 | Downstream read command ready |
| m_arid | output | ID_W | Read command ID |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | LEN_W | Read beats minus one |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |
| m_rid | input | ID_W | Read data ID |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |
| m_awvalid | output | 1 | Downstream write command valid |
| m_awready | input | 1 | Downstream write command ready |
| m_awid | output | ID_W | Write command ID |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | LEN_W | Write beats minus one |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_bid | input | ID_W | Write response ID |
| m_bresp | input | 2 | Write response code |

## Verification
The bench blocks the engine in the middle of a read burst that is partly done. It checks that only the remaining beats are generated. An engine that restarted the count from the command length would emit extra beats and misplace rlast. A write is left one data beat short at the moment of the block. The bench checks that no error response appears before its wlast, which catches an engine that answers writes on command receipt. A sweep fills the read queue to its depth with mixed IDs and lengths under back-pressure and then drains it. This exposes a queue that overflows, keeps s_arready high when full, or reorders responses within an ID. An unblock issued while reads are still owed must be ignored, and one issued after the drain must restore pass-through. A premature or lost unblock would show up on the downstream valid and ready lines.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam logic [1:0]  RESP_OKAY   = 2'b00;
  localparam logic [1:0]  RESP_SLVERR = 2'b10;
  localparam logic [31:0] FILL_WORD   = 32'hDEADFA11;

  // bit i of the filler data: the 32-bit word tiled across the bus
  function automatic logic fill_bit(input int i);
    return FILL_WORD[i % 32];
  endfunction
endpackage

// File: rtl/axf_track_q.sv
// Age-ordered tracker: index 0 is the oldest entry. Entries can be
// retired from any position (matching by ID), the rest shift down.
module axf_track_q #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 2,
  parameter int LEN_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_en,
  input  logic [ID_W-1:0]              push_id,
  input  logic [LEN_W-1:0]             push_len,
  input  logic                         hit_en,
  input  logic [ID_W-1:0]              hit_id,
  input  logic                         hit_last,
  input  logic                         wbeat_en,
  input  logic                         wbeat_last,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic [ID_W-1:0]              head_id,
  output logic [LEN_W:0]               head_left,
  output logic                         head_wdone,
  output logic                         wneed
);
  localparam int BT_W  = LEN_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0]  q_id   [DEPTH];
  logic [BT_W-1:0]  q_left [DEPTH];
  logic             q_wd   [DEPTH];
  logic [CNT_W-1:0] cnt;

  logic [ID_W-1:0]  n_id   [DEPTH];
  logic [BT_W-1:0]  n_left [DEPTH];
  logic             n_wd   [DEPTH];
  logic [CNT_W-1:0] n_cnt;

  int   h_idx, w_idx;
  logic h_hit, w_hit;
  logic rm;

  // oldest entry with the given ID, and oldest entry still owed wlast
  always_comb begin
    h_hit = 1'b0; h_idx = 0;
    w_hit = 1'b0; w_idx = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < int'(cnt) && q_id[i] == hit_id) begin
        h_hit = 1'b1; h_idx = i;
      end
      if (i < int'(cnt) && !q_wd[i]) begin
        w_hit = 1'b1; w_idx = i;
      end
    end
  end

  always_comb begin
    logic [ID_W-1:0] m_id   [DEPTH];
    logic [BT_W-1:0] m_left [DEPTH];
    logic            m_wd   [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin
      m_id[i] = q_id[i]; m_left[i] = q_left[i]; m_wd[i] = q_wd[i];
    end
    rm = 1'b0;
    if (wbeat_en && wbeat_last && w_hit) m_wd[w_idx] = 1'b1;
    if (hit_en && h_hit) begin
      if (hit_last) rm = 1'b1;
      else m_left[h_idx] = m_left[h_idx] - BT_W'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = (rm && i >= h_idx && i < DEPTH - 1) ? i + 1 : i;
      n_id[i] = m_id[j]; n_left[i] = m_left[j]; n_wd[i] = m_wd[j];
    end
    n_cnt = cnt - CNT_W'(rm);
    for (int i = 0; i < DEPTH; i++) begin
      if (push_en && i == int'(n_cnt)) begin
        n_id[i]   = push_id;
        n_left[i] = BT_W'(push_len) + BT_W'(1);
        n_wd[i]   = 1'b0;
      end
    end
    n_cnt = n_cnt + CNT_W'(push_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= n_cnt;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      q_id[i]   <= n_id[i];
      q_left[i] <= n_left[i];
      q_wd[i]   <= n_wd[i];
    end
  end

  assign count      = cnt;
  assign full       = (cnt == CNT_W'(DEPTH));
  assign empty      = (cnt == '0);
  assign head_id    = q_id[0];
  assign head_left  = q_left[0];
  assign head_wdone = q_wd[0];
  assign wneed      = w_hit;
endmodule

// File: rtl/axf_mode_ctl.sv
module axf_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_req,
  input  logic unblk_req,
  input  logic rd_idle,
  input  logic wr_idle,
  output logic blocked
);
  logic blk_q;
  logic unblk_ok;

  assign unblk_ok = unblk_req && rd_idle && wr_idle;

  always_ff @(posedge clk) begin
    if (!rst_n)        blk_q <= 1'b0;
    else if (blk_req)  blk_q <= 1'b1;
    else if (unblk_ok) blk_q <= 1'b0;
  end

  assign blocked = blk_q;
endmodule

// File: rtl/axf_fw.sv
module axf_fw
  import axf_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_req,
  input  logic                unblk_req,
  output logic                rd_busy,
  output logic                wr_busy,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ID_W-1:0]     s_arid,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [LEN_W-1:0]    s_arlen,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_W-1:0]     s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [LEN_W-1:0]    s_awlen,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ID_W-1:0]     m_arid,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [LEN_W-1:0]    m_arlen,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [ID_W-1:0]     m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BT_W  = LEN_W + 1;

  // named internal events, also used by the bound checker
  logic             blocked;
  logic             ar_fire, aw_fire, w_fire, r_fire, b_fire;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic             rd_full, wr_full, rd_empty, wr_empty;
  logic [ID_W-1:0]  rq_head_id, wq_head_id;
  logic [BT_W-1:0]  rq_head_left;
  logic             wq_head_wdone, wq_wneed;
  logic [DATA_W-1:0] fill_data;

  logic [BT_W-1:0]  wq_left_unused;
  logic             rq_wdone_unused, rq_wneed_unused;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) fill_data[i] = fill_bit(i);
  end

  // read command: pass-through or absorb
  assign s_arready = !rd_full && (blocked || m_arready);
  assign m_arvalid = s_arvalid && !rd_full && !blocked;
  assign m_arid    = s_arid;
  assign m_araddr  = s_araddr;
  assign m_arlen   = s_arlen;
  assign ar_fire   = s_arvalid && s_arready;

  // write command
  assign s_awready = !wr_full && (blocked || m_awready);
  assign m_awvalid = s_awvalid && !wr_full && !blocked;
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign aw_fire   = s_awvalid && s_awready;

  // write data: only for a recorded write still owed data
  assign s_wready = wq_wneed && (blocked || m_wready);
  assign m_wvalid = s_wvalid && wq_wneed && !blocked;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = s_wlast;
  assign w_fire   = s_wvalid && s_wready;

  // read data: downstream or self-generated
  assign s_rvalid = blocked ? !rd_empty : m_rvalid;
  assign s_rid    = blocked ? rq_head_id : m_rid;
  assign s_rdata  = blocked ? fill_data : m_rdata;
  assign s_rresp  = blocked ? RESP_SLVERR : m_rresp;
  assign s_rlast  = blocked ? (rq_head_left == BT_W'(1)) : m_rlast;
  assign m_rready = blocked || s_rready;
  assign r_fire   = s_rvalid && s_rready;

  // write response
  assign s_bvalid = blocked ? (!wr_empty && wq_head_wdone) : m_bvalid;
  assign s_bid    = blocked ? wq_head_id : m_bid;
  assign s_bresp  = blocked ? RESP_SLVERR : m_bresp;
  assign m_bready = blocked || s_bready;
  assign b_fire   = s_bvalid && s_bready;

  assign rd_busy = !rd_empty || s_arvalid;
  assign wr_busy = !wr_empty || s_awvalid || s_wvalid;

  axf_mode_ctl i_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_req   (blk_req),
    .unblk_req (unblk_req),
    .rd_idle   (!rd_busy),
    .wr_idle   (!wr_busy),
    .blocked   (blocked)
  );

  axf_track_q #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W)) i_rq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (ar_fire),
    .push_id    (s_arid),
    .push_len   (s_arlen),
    .hit_en     (r_fire),
    .hit_id     (s_rid),
    .hit_last   (s_rlast),
    .wbeat_en   (1'b0),
    .wbeat_last (1'b0),
    .count      (rd_cnt),
    .full       (rd_full),
    .empty      (rd_empty),
    .head_id    (rq_head_id),
    .head_left  (rq_head_left),
    .head_wdone (rq_wdone_unused),
    .wneed      (rq_wneed_unused)
  );

  axf_track_q #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W)) i_wq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (aw_fire),
    .push_id    (s_awid),
    .push_len   (s_awlen),
    .hit_en     (b_fire),
    .hit_id     (s_bid),
    .hit_last   (1'b1),
    .wbeat_en   (w_fire),
    .wbeat_last (s_wlast),
    .count      (wr_cnt),
    .full       (wr_full),
    .empty      (wr_empty),
    .head_id    (wq_head_id),
    .head_left  (wq_left_unused),
    .head_wdone (wq_head_wdone),
    .wneed      (wq_wneed)
  );
endmodule

// File: rtl/axf_fw_chk.sv
module axf_fw_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  parameter int ID_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       blocked,
  input logic [$clog2(DEPTH+1)-1:0] rd_cnt,
  input logic [$clog2(DEPTH+1)-1:0] wr_cnt,
  input logic                       m_arvalid,
  input logic                       m_awvalid,
  input logic                       m_wvalid,
  input logic                       m_rready,
  input logic                       m_bready,
  input logic                       s_arvalid,
  input logic                       s_arready,
  input logic                       s_awvalid,
  input logic                       s_awready,
  input logic                       s_wvalid,
  input logic                       s_rvalid,
  input logic                       s_rready,
  input logic [ID_W-1:0]            s_rid,
  input logic [DATA_W-1:0]          s_rdata,
  input logic [1:0]                 s_rresp,
  input logic                       s_bvalid,
  input logic [1:0]                 s_bresp,
  input logic                       rd_busy,
  input logic                       wr_busy
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  logic [DATA_W-1:0] pat;
  always_comb begin
    for (int i = 0; i < DATA_W; i++) pat[i] = axf_pkg::FILL_WORD[i % 32];
  end

  p_cutoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!m_arvalid && !m_awvalid && !m_wvalid && m_rready && m_bready));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == CNT_W'(DEPTH)) |-> !s_arready);

  p_no_overflow_w_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt == CNT_W'(DEPTH)) |-> !s_awready);

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && s_rvalid) |-> (s_rdata == pat && s_rresp == 2'b10));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rid)));

  p_bresp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && s_bvalid) |-> (s_bresp == 2'b10));

  p_rbusy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid |-> rd_busy);

  p_wbusy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid || s_wvalid) |-> wr_busy);

  p_unblock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blocked) |-> (rd_cnt == '0 && wr_cnt == '0));
endmodule

bind axf_fw axf_fw_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ID_W(ID_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blocked   (blocked),
  .rd_cnt    (rd_cnt),
  .wr_cnt    (wr_cnt),
  .m_arvalid (m_arvalid),
  .m_awvalid (m_awvalid),
  .m_wvalid  (m_wvalid),
  .m_rready  (m_rready),
  .m_bready  (m_bready),
  .s_arvalid (s_arvalid),
  .s_arready (s_arready),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .s_wvalid  (s_wvalid),
  .s_rvalid  (s_rvalid),
  .s_rready  (s_rready),
  .s_rid     (s_rid),
  .s_rdata   (s_rdata),
  .s_rresp   (s_rresp),
  .s_bvalid  (s_bvalid),
  .s_bresp   (s_bresp),
  .rd_busy   (rd_busy),
  .wr_busy   (wr_busy)
);

// File: tb/test_axf_fw.sv
module test_axf_fw;
  localparam int ID_W = 2, ADDR_W = 16, DATA_W = 64, LEN_W = 8, DEPTH = 8;

  logic clk = 0, rst_n = 0, blk_req = 0, unblk_req = 0;
  logic rd_busy, wr_busy;
  logic s_arvalid = 0, s_arready; logic [ID_W-1:0] s_arid = 0;
  logic [ADDR_W-1:0] s_araddr = 0; logic [LEN_W-1:0] s_arlen = 0;
  logic s_rvalid, s_rready = 0; logic [ID_W-1:0] s_rid;
  logic [DATA_W-1:0] s_rdata; logic [1:0] s_rresp; logic s_rlast;
  logic s_awvalid = 0, s_awready; logic [ID_W-1:0] s_awid = 0;
  logic [ADDR_W-1:0] s_awaddr = 0; logic [LEN_W-1:0] s_awlen = 0;
  logic s_wvalid = 0, s_wready; logic [DATA_W-1:0] s_wdata = 0;
  logic [DATA_W/8-1:0] s_wstrb = '1; logic s_wlast = 0;
  logic s_bvalid, s_bready = 0; logic [ID_W-1:0] s_bid; logic [1:0] s_bresp;
  logic m_arvalid, m_arready = 0; logic [ID_W-1:0] m_arid;
  logic [ADDR_W-1:0] m_araddr; logic [LEN_W-1:0] m_arlen;
  logic m_rvalid = 0, m_rready; logic [ID_W-1:0] m_rid = 0;
  logic [DATA_W-1:0] m_rdata = 0; logic [1:0] m_rresp = 0; logic m_rlast = 0;
  logic m_awvalid, m_awready = 0; logic [ID_W-1:0] m_awid;
  logic [ADDR_W-1:0] m_awaddr; logic [LEN_W-1:0] m_awlen;
  logic m_wvalid, m_wready = 0; logic [DATA_W-1:0] m_wdata;
  logic [DATA_W/8-1:0] m_wstrb; logic m_wlast;
  logic m_bvalid = 0, m_bready; logic [ID_W-1:0] m_bid = 0; logic [1:0] m_bresp = 0;

  axf_fw #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) i_axf_fw (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int mq_id[$];
  int mq_n[$];
  logic [63:0] fill_exp;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // drain all modelled reads in issue order, checking every beat
  task automatic drain_reads();
    while (mq_id.size() > 0) begin
      int id; int n;
      id = mq_id.pop_front(); n = mq_n.pop_front();
      for (int b = 0; b < n; b++) begin
        s_rready = 1; #1;
        chk("R4 rvalid", s_rvalid, 1);
        chk("R6 rid order", s_rid, id);
        chk("R4 rlast", s_rlast, (b == n - 1));
        chk("R4 rdata fill", s_rdata, fill_exp);
        chk("R4 rresp", s_rresp, 2);
        tick();
      end
    end
    s_rready = 0; #1;
    chk("R8 rd_busy after drain", rd_busy, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fill_exp = (64'hDEADFA11 << 32) | 64'hDEADFA11;
    @(negedge clk); rst_n = 0; tick(); tick(); rst_n = 1; tick(); #1;
    chk("R8 reset rd_busy", rd_busy, 0);
    chk("R8 reset wr_busy", wr_busy, 0);
    chk("R2 reset m_bready follows", m_bready, 0);

    // R12: W with no AW is not accepted
    s_wvalid = 1; m_wready = 1; #1;
    chk("R12 wready without aw", s_wready, 0);
    chk("R12 no m_wvalid", m_wvalid, 0);
    chk("R8 wr_busy on wvalid", wr_busy, 1);
    tick(); s_wvalid = 0; m_wready = 0;

    // R1: read command pass-through
    s_arvalid = 1; s_arid = 1; s_araddr = 16'h1234; s_arlen = 3; m_arready = 1; #1;
    chk("R1 m_arvalid", m_arvalid, 1);
    chk("R1 m_arid", m_arid, 1);
    chk("R1 m_araddr", m_araddr, 16'h1234);
    chk("R1 m_arlen", m_arlen, 3);
    chk("R1 s_arready", s_arready, 1);
    chk("R8 rd_busy", rd_busy, 1);
    tick(); s_arvalid = 0; m_arready = 0;

    // R1 / R10: one downstream beat returned before the block
    m_rvalid = 1; m_rid = 1; m_rdata = 64'h0123456789ABCDEF; m_rresp = 0; m_rlast = 0;
    s_rready = 1; #1;
    chk("R1 s_rvalid", s_rvalid, 1);
    chk("R1 s_rdata", s_rdata, 64'h0123456789ABCDEF);
    chk("R1 s_rid", s_rid, 1);
    chk("R1 m_rready", m_rready, 1);
    tick(); m_rvalid = 0; s_rready = 0; #1;
    chk("R8 rd_busy mid burst", rd_busy, 1);
    mq_id.push_back(1); mq_n.push_back(3);

    // R1: write command and first W beat
    s_awvalid = 1; s_awid = 2; s_awlen = 1; s_awaddr = 16'h0040; m_awready = 1; #1;
    chk("R1 m_awvalid", m_awvalid, 1);
    chk("R1 m_awid", m_awid, 2);
    tick(); s_awvalid = 0; m_awready = 0;
    s_wvalid = 1; s_wdata = 64'hA5A5; s_wlast = 0; m_wready = 1; #1;
    chk("R1 m_wvalid", m_wvalid, 1);
    chk("R1 m_wdata", m_wdata, 64'hA5A5);
    chk("R12 s_wready", s_wready, 1);
    tick(); s_wvalid = 0; m_wready = 0;

    // R11: block takes effect after the sampling edge
    blk_req = 1; #1;
    chk("R11 not yet blocked", m_bready, 0);
    tick(); blk_req = 0; #1;
    chk("R11 R2 m_bready", m_bready, 1);
    chk("R2 m_rready", m_rready, 1);

    // R7: commands during block absorbed
    s_arvalid = 1; s_arid = 1; s_arlen = 0; m_arready = 1; #1;
    chk("R7 R2 m_arvalid", m_arvalid, 0);
    chk("R7 s_arready", s_arready, 1);
    tick(); mq_id.push_back(1); mq_n.push_back(1);
    s_arid = 0; s_arlen = 1; tick(); mq_id.push_back(0); mq_n.push_back(2);
    s_arvalid = 0; m_arready = 0;

    // R5: write missing its last beat gets no response
    #1; chk("R5 no b before wlast", s_bvalid, 0);
    s_wvalid = 1; s_wlast = 1; m_wready = 1; #1;
    chk("R2 R7 m_wvalid", m_wvalid, 0);
    chk("R7 s_wready", s_wready, 1);
    tick(); s_wvalid = 0; s_wlast = 0; m_wready = 0; #1;
    chk("R5 bvalid", s_bvalid, 1);
    chk("R5 bid", s_bid, 2);
    chk("R5 bresp", s_bresp, 2);
    s_bready = 1; tick(); s_bready = 0;

    // R7 / R5: write arriving during block
    s_awvalid = 1; s_awid = 3; s_awlen = 2; m_awready = 1; #1;
    chk("R7 m_awvalid", m_awvalid, 0);
    chk("R7 s_awready", s_awready, 1);
    tick(); s_awvalid = 0; m_awready = 0;
    for (int k = 0; k < 3; k++) begin
      #1; chk("R5 b held", s_bvalid, 0);
      s_wvalid = 1; s_wlast = (k == 2); tick();
    end
    s_wvalid = 0; s_wlast = 0; #1;
    chk("R5 bvalid late", s_bvalid, 1);
    chk("R5 bid late", s_bid, 3);
    s_bready = 1; tick(); s_bready = 0; #1;
    chk("R8 wr_busy clear", wr_busy, 0);

    // R9: unblock refused while reads owed
    unblk_req = 1; tick(); unblk_req = 0; #1;
    chk("R9 still blocked", m_bready, 1);

    // R4: stall holds the beat
    #1; chk("R4 stall rid", s_rid, 1);
    tick(); #1;
    chk("R4 stall hold", s_rvalid, 1);
    chk("R4 stall rlast", s_rlast, 0);
    drain_reads();

    // R3: fill the read queue with mixed IDs and lengths
    for (int i = 0; i < DEPTH; i++) begin
      s_arvalid = 1; s_arid = ID_W'(i % 4); s_arlen = LEN_W'(i % 3); #1;
      chk("R3 accept below depth", s_arready, 1);
      tick();
      mq_id.push_back(i % 4); mq_n.push_back(i % 3 + 1);
    end
    #1;
    chk("R3 full s_arready", s_arready, 0);
    chk("R8 rd_busy full", rd_busy, 1);
    s_arvalid = 0;
    drain_reads();

    // R9: unblock accepted when idle
    unblk_req = 1; tick(); unblk_req = 0; #1;
    chk("R9 unblocked m_bready", m_bready, 0);
    s_arvalid = 1; s_arid = 2; s_arlen = 0; m_arready = 1; #1;
    chk("R9 R1 pass-through", m_arvalid, 1);
    tick(); s_arvalid = 0; m_arready = 0;
    m_rvalid = 1; m_rid = 2; m_rresp = 0; m_rlast = 1; m_rdata = 64'h77; s_rready = 1; #1;
    chk("R1 rresp okay", s_rresp, 0);
    chk("R1 rlast", s_rlast, 1);
    tick(); m_rvalid = 0; s_rready = 0; #1;
    chk("R8 rd_busy final", rd_busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule